// File: doc/BRIEF.md
# UART FIFO DMA Ready Signalling

This block drives the two active-low DMA request outputs of one FIFO-based serial channel: a receive-side request that tells a DMA engine characters can be fetched, and a transmit-side request that tells it characters can be written. The FIFO storage, the trigger-level comparator and the character timeout counter are outside the block. Their results reach it as inputs: the receive FIFO occupancy, a trigger flag, a timeout flag, the transmit FIFO empty and full flags, and one-cycle strobes for each character that arrives, is read or is loaded.

Two signalling styles are supported. Single-transfer style follows occupancy: a request is active while there is something to move. Burst style uses set/reset flags: the request becomes active on a start condition and stays active until an end condition. Burst style is selected by a mode bit, but only when FIFO operation is enabled. With FIFO operation off, the block always uses single-transfer style. In FIFO operation a newly arrived character becomes visible to the receive request only after a fixed number of receive clock ticks.

Top module: `uart_dma_ready`

## Requirements
- R1: With `fifo_on` low the block uses single-transfer style on both outputs whatever `burst_sel` says. Burst style applies only when both `fifo_on` and `burst_sel` are high.
- R2: In single-transfer style `rx_req_n` goes low once an arrived character is visible and `rx_level` is non-zero. It is high whenever `rx_level` is zero.
- R3: In burst style `rx_req_n` goes low when a visible character is held and either `rx_trig` or `rx_tmo` is high. It then stays low, even after both flags drop, until the receive FIFO is emptied.
- R4: In single-transfer style `tx_req_n` is low while `tx_empty` is high and goes high on the clock after a `tx_load` strobe, even if `tx_empty` has not yet fallen.
- R5: In burst style `tx_req_n` goes low when `tx_empty` is high and then stays low until `tx_full` is seen. After that it stays high until the FIFO is empty again.
- R6: With `fifo_on` high, a character marked by `rx_done` becomes visible only after RX_DLY (default 3) further `rclk_tick` pulses. Cycles without a tick do not count. With `fifo_on` low it is visible on the next clock.
- R7: While `rst` is high and on the first clock after it, `rx_req_n` is high and `tx_req_n` is low.
- R8: A `rx_read` strobe while `rx_level` is 1 releases `rx_req_n` on the next clock. The block does not wait for the level to reach zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_on | input | 1 | FIFO operation enable |
| burst_sel | input | 1 | Burst DMA style select (used only with fifo_on) |
| rclk_tick | input | 1 | Receive clock tick, one clock wide |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| rx_trig | input | 1 | Receive trigger level reached |
| rx_tmo | input | 1 | Receive character timeout |
| rx_done | input | 1 | Strobe: a character finished arriving |
| rx_read | input | 1 | Strobe: a character is read from the receive FIFO |
| tx_empty | input | 1 | Transmit FIFO/holding register empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_load | input | 1 | Strobe: a character is loaded for transmit |
| rx_req_n | output | 1 | Receive DMA request, active low, registered |
| tx_req_n | output | 1 | Transmit DMA request, active low, registered |

## Verification
The hardest state to reach is a burst-style receive request that is still held after its trigger or timeout flag has gone away. Getting there takes a character that has already matured through the arrival delay, then a pulse on the start flag, then a drop in occupancy that does not reach zero. The bench builds this sequence one cycle at a time. It also stalls `rclk_tick` in the middle of the arrival delay to show that only ticks advance it. Each DMA style is exercised separately, and the compatibility case with `burst_sel` high and `fifo_on` low is run on both outputs.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BURST  = 1'b1
  } dma_style_e;

  function automatic dma_style_e pick_style(input logic fifo_on, input logic burst_sel);
    return (fifo_on && burst_sel) ? DMA_BURST : DMA_SINGLE;
  endfunction
endpackage

// File: rtl/rx_arrival_delay.sv
module rx_arrival_delay #(
  parameter int RX_DLY = 3,
  localparam int DW = $clog2(RX_DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic fifo_on,
  input  logic rclk_tick,
  input  logic rx_done,
  output logic visible_now
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (rx_done && fifo_on) begin
      cnt_q <= DW'(RX_DLY);
    end else if (!fifo_on) begin
      cnt_q <= '0;
    end else if (rclk_tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // A fresh arrival restarts the window and cancels a pending one.
  always_comb begin
    if (fifo_on) visible_now = !rx_done && rclk_tick && (cnt_q == DW'(1));
    else         visible_now = rx_done;
  end
endmodule

// File: rtl/rx_ready_ctl.sv
module rx_ready_ctl
  import uart_dma_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  dma_style_e       style,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             rx_read,
  input  logic             visible_now,
  output logic             rx_req_n
);
  logic seen_q, burst_q;
  logic seen_d, burst_d, empty_soon;

  always_comb begin
    empty_soon = (rx_level == '0) || (rx_read && rx_level == CNT_W'(1));
    seen_d     = !empty_soon && (visible_now || seen_q);
    burst_d    = !empty_soon && (burst_q || (seen_d && (rx_trig || rx_tmo)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      burst_q  <= 1'b0;
      rx_req_n <= 1'b1;
    end else begin
      seen_q   <= seen_d;
      burst_q  <= burst_d;
      rx_req_n <= (style == DMA_BURST) ? !burst_d : !seen_d;
    end
  end
endmodule

// File: rtl/tx_ready_ctl.sv
module tx_ready_ctl
  import uart_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dma_style_e style,
  input  logic       tx_empty,
  input  logic       tx_full,
  input  logic       tx_load,
  output logic       tx_req_n
);
  logic burst_q, burst_d;

  always_comb begin
    if (tx_empty && !tx_load) burst_d = 1'b1;
    else if (tx_full)         burst_d = 1'b0;
    else                      burst_d = burst_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q  <= 1'b1;
      tx_req_n <= 1'b0;
    end else begin
      burst_q  <= burst_d;
      tx_req_n <= (style == DMA_BURST) ? !burst_d : (tx_load || !tx_empty);
    end
  end
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int RX_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_on,
  input  logic             burst_sel,
  input  logic             rclk_tick,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             rx_done,
  input  logic             rx_read,
  input  logic             tx_empty,
  input  logic             tx_full,
  input  logic             tx_load,
  output logic             rx_req_n,
  output logic             tx_req_n
);
  dma_style_e style;
  logic       visible_now;

  assign style = pick_style(fifo_on, burst_sel);

  rx_arrival_delay #(.RX_DLY(RX_DLY)) u_dly (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .rclk_tick(rclk_tick),
    .rx_done(rx_done), .visible_now(visible_now)
  );

  rx_ready_ctl #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .style(style), .rx_level(rx_level),
    .rx_trig(rx_trig), .rx_tmo(rx_tmo), .rx_read(rx_read),
    .visible_now(visible_now), .rx_req_n(rx_req_n)
  );

  tx_ready_ctl u_tx (
    .clk(clk), .rst(rst), .style(style), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_load(tx_load), .tx_req_n(tx_req_n)
  );
endmodule

// File: rtl/uart_dma_ready_chk.sv
module uart_dma_ready_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_on,
  input logic             burst_sel,
  input logic [CNT_W-1:0] rx_level,
  input logic             rx_done,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             tx_load,
  input logic             rx_req_n,
  input logic             tx_req_n
);
  logic burst;
  assign burst = fifo_on && burst_sel;

  assert_reset_levels_R7: assert property (@(posedge clk)
    $past(rst) |-> (rx_req_n && !tx_req_n));

  assert_rx_empty_release_R2: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> rx_req_n);

  assert_rx_arrival_hidden_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_on && !burst_sel && $past(fifo_on && !burst_sel) && rx_done && rx_req_n) |=> rx_req_n);

  assert_rx_burst_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (burst && $past(burst) && !rx_req_n && rx_level > CNT_W'(1)) |=> !rx_req_n);

  assert_tx_load_release_R4: assert property (@(posedge clk) disable iff (rst)
    (!burst && tx_load) |=> tx_req_n);

  assert_tx_full_release_R5: assert property (@(posedge clk) disable iff (rst)
    (burst && tx_full && !tx_empty) |=> tx_req_n);

  assert_tx_burst_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (burst && $past(burst) && !tx_empty && !tx_full) |=> $stable(tx_req_n));
endmodule

bind uart_dma_ready uart_dma_ready_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_on(fifo_on), .burst_sel(burst_sel),
  .rx_level(rx_level), .rx_done(rx_done), .tx_empty(tx_empty),
  .tx_full(tx_full), .tx_load(tx_load), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
);

// File: tb/uart_dma_ready_bench.sv
module uart_dma_ready_bench;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_on = 0, burst_sel = 0, rclk_tick = 1;
  logic [CNT_W-1:0] rx_level = '0;
  logic rx_trig = 0, rx_tmo = 0, rx_done = 0, rx_read = 0;
  logic tx_empty = 1, tx_full = 0, tx_load = 0;
  logic rx_req_n, tx_req_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  uart_dma_ready #(.CNT_W(CNT_W), .RX_DLY(3)) u_uart_dma_ready (
    .clk(clk), .rst(rst), .fifo_on(fifo_on), .burst_sel(burst_sel),
    .rclk_tick(rclk_tick), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_tmo(rx_tmo), .rx_done(rx_done), .rx_read(rx_read),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_load(tx_load),
    .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    check("R7 rx in reset", rx_req_n, 1'b1);
    check("R7 tx in reset", tx_req_n, 1'b0);
    rst = 0; tick();
    check("R7 rx after reset", rx_req_n, 1'b1);
    check("R7 tx after reset", tx_req_n, 1'b0);
  endtask

  task automatic t_rx_single_nofifo();
    fifo_on = 0; burst_sel = 0;
    rx_level = 1; rx_done = 1; tick();
    check("R2 rx low after arrival", rx_req_n, 1'b0);
    rx_done = 0; rx_level = 2; tick();
    check("R2 rx low while held", rx_req_n, 1'b0);
    rx_read = 1; tick();
    check("R2 rx low after non-last read", rx_req_n, 1'b0);
    rx_read = 0; rx_level = 1; tick();
    check("R2 rx low one left", rx_req_n, 1'b0);
    rx_read = 1; tick();
    check("R8 rx high on last read", rx_req_n, 1'b1);
    rx_read = 0; rx_level = 0; tick();
    check("R2 rx high when empty", rx_req_n, 1'b1);
  endtask

  task automatic t_rx_delay();
    fifo_on = 1; burst_sel = 0; rclk_tick = 1;
    rx_level = 1; rx_done = 1; tick();
    check("R6 hidden at arrival", rx_req_n, 1'b1);
    rx_done = 0; tick();
    check("R6 hidden tick1", rx_req_n, 1'b1);
    tick();
    check("R6 hidden tick2", rx_req_n, 1'b1);
    tick();
    check("R6 visible tick3", rx_req_n, 1'b0);
    rx_level = 0; tick();
    check("R2 release after delay test", rx_req_n, 1'b1);
    // stall the receive clock mid-window
    rx_level = 1; rx_done = 1; tick();
    rx_done = 0; rclk_tick = 0;
    for (int i = 0; i < 4; i++) tick();
    check("R6 no tick no progress", rx_req_n, 1'b1);
    rclk_tick = 1; tick(); tick();
    check("R6 two ticks still hidden", rx_req_n, 1'b1);
    tick();
    check("R6 visible after third tick", rx_req_n, 1'b0);
    rx_level = 0; tick();
  endtask

  task automatic t_rx_burst();
    fifo_on = 1; burst_sel = 1; rclk_tick = 1;
    rx_level = 1; rx_done = 1; tick();
    rx_done = 0; tick(); tick(); tick();
    check("R3 no start flag stays high", rx_req_n, 1'b1);
    rx_level = 4; rx_trig = 1; tick();
    check("R3 low on trigger", rx_req_n, 1'b0);
    rx_trig = 0; rx_level = 2; tick();
    check("R3 held after trigger drops", rx_req_n, 1'b0);
    rx_level = 0; tick();
    check("R3 release on empty", rx_req_n, 1'b1);
    rx_level = 1; rx_done = 1; tick();
    rx_done = 0; tick(); tick(); tick();
    check("R3 waiting for timeout", rx_req_n, 1'b1);
    rx_tmo = 1; tick();
    check("R3 low on timeout", rx_req_n, 1'b0);
    rx_tmo = 0; tick();
    check("R3 held after timeout drops", rx_req_n, 1'b0);
    rx_read = 1; tick();
    check("R8 burst release on last read", rx_req_n, 1'b1);
    rx_read = 0; rx_level = 0; tick();
  endtask

  task automatic t_rx_compat();
    fifo_on = 0; burst_sel = 1;
    rx_level = 1; rx_done = 1; tick();
    check("R1 rx single style without fifo", rx_req_n, 1'b0);
    rx_done = 0; rx_level = 0; tick();
    check("R1 rx release without fifo", rx_req_n, 1'b1);
  endtask

  task automatic t_tx_single();
    fifo_on = 0; burst_sel = 0; tx_empty = 1; tx_full = 0;
    tick();
    check("R4 tx low when empty", tx_req_n, 1'b0);
    tx_load = 1; tick();
    check("R4 tx high after load", tx_req_n, 1'b1);
    tx_load = 0; tx_empty = 0; tick();
    check("R4 tx high while occupied", tx_req_n, 1'b1);
    tx_empty = 1; tick();
    check("R4 tx low again when empty", tx_req_n, 1'b0);
  endtask

  task automatic t_tx_burst();
    fifo_on = 1; burst_sel = 1; tx_empty = 1; tx_full = 0;
    tick();
    check("R5 tx low when empty", tx_req_n, 1'b0);
    tx_load = 1; tx_empty = 0; tick();
    check("R5 tx held on load", tx_req_n, 1'b0);
    tx_load = 0; tick();
    check("R5 tx held partial", tx_req_n, 1'b0);
    tx_full = 1; tick();
    check("R5 tx high on full", tx_req_n, 1'b1);
    tx_full = 0; tick();
    check("R5 tx held high after drain", tx_req_n, 1'b1);
    tx_empty = 1; tick();
    check("R5 tx low on empty", tx_req_n, 1'b0);
  endtask

  task automatic t_tx_compat();
    fifo_on = 0; burst_sel = 1; tx_empty = 1; tx_full = 0;
    tick();
    check("R1 tx low when empty", tx_req_n, 1'b0);
    tx_load = 1; tx_empty = 0; tick();
    check("R1 tx single style after load", tx_req_n, 1'b1);
    tx_load = 0; tick();
    check("R1 tx stays high partial", tx_req_n, 1'b1);
    tx_empty = 1; tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rx_single_nofifo();
    t_rx_delay();
    t_rx_burst();
    t_rx_compat();
    t_tx_single();
    t_tx_burst();
    t_tx_compat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule